// File: doc/BRIEF.md
# Self-Starting Skip-Sequence Counter

This block is a 3-bit state machine whose state is its only output. Each enabled clock moves it one step around a fixed loop of five codes: 000, 010, 011, 101, 110, then back to 000. The other three codes (001, 100 and 111) are not part of the loop. Each has a defined successor, so a register that wakes up holding one of them rejoins the loop within two enabled clocks and needs no reset to recover.

The next-state logic is selected when the block is built. The default build computes each bit's next value directly, in the form a D register uses. Setting `USE_TOGGLE` to 1 builds it instead as per-bit toggle conditions applied to the present state. Both builds give the same successor for all eight codes.

A synchronous clear and a synchronous load complete the control. The load lets a surrounding block place the machine in any code, including the three unused ones.

Top module: `skipSeqCounter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 000. This takes priority over load and enable.
- R2: With `rst` and `loadEn` low and `enable` high, each rising edge advances the state (bit 2 = C, bit 1 = B, bit 0 = A) along the loop 000→010→011→101→110→000.
- R3: With `rst`, `loadEn` and `enable` all low, the state keeps its value across the edge.
- R4: With `rst` low and `loadEn` high, the state takes the value of `loadVal` at the next edge, whatever the level of `enable`.
- R5: The unused code 001 advances to 100 on an enabled step, and 100 advances to 000.
- R6: The unused code 111 advances to 110 on an enabled step.
- R7: From any of the eight codes, at most two enabled steps reach a code inside the loop.
- R8: A build with `USE_TOGGLE` = 1 produces the same successor as the default build for each of the eight codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear to 000, active high |
| enable | input | 1 | Advances the state one step when high |
| loadEn | input | 1 | Synchronous load of `loadVal`, active high |
| loadVal | input | 3 | Code to load |
| stateOut | output | 3 | Present state {C,B,A} |

## Verification
The loop is checked in two ways. Plain stepping from a clear shows that the five codes appear in order and wrap correctly. Single steps from each of the eight loaded codes pin down every successor individually, which separates a fault in a loop transition from a fault in the mapping of an unused code. Recovery runs from 001, 100 and 111 count the steps needed to enter the loop. A toggle build stepped next to the default build, code by code, shows whether the two sets of equations disagree on any input. Hold runs with enable low, and loads issued while enable is high, show whether step has wrongly taken priority over hold or load.

// File: rtl/skipSeqPkg.sv
package skipSeqPkg;
  localparam int STATE_W = 3;
  typedef logic [STATE_W-1:0] state_t;

  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } ctlStrobe_t;
endpackage

// File: rtl/skipSeqNext.sv
module skipSeqNext
  import skipSeqPkg::*;
#(
  parameter bit USE_TOGGLE = 1'b0
) (
  input  state_t cur,
  output state_t nxt
);
  logic bitC, bitB, bitA;
  assign bitC = cur[2];
  assign bitB = cur[1];
  assign bitA = cur[0];

  generate
    if (USE_TOGGLE) begin : g_toggle
      logic togC, togB, togA;
      always_comb begin
        togC = bitA ^ bitC;
        togB = bitB ^ ~(bitA ^ bitC);
        togA = bitA ^ (bitB & ~bitC);
        nxt  = cur ^ {togC, togB, togA};
      end
    end else begin : g_direct
      always_comb begin
        nxt = {bitA, ~(bitA ^ bitC), bitB & ~bitC};
      end
    end
  endgenerate
endmodule

// File: rtl/skipSeqCtrl.sv
module skipSeqCtrl
  import skipSeqPkg::*;
(
  input  logic       rst,
  input  logic       enable,
  input  logic       loadEn,
  output ctlStrobe_t ctl
);
  always_comb begin
    ctl.clear = rst;
    ctl.load  = !rst && loadEn;
    ctl.step  = !rst && !loadEn && enable;
  end
endmodule

// File: rtl/skipSeqDatapath.sv
module skipSeqDatapath
  import skipSeqPkg::*;
#(
  parameter bit USE_TOGGLE = 1'b0
) (
  input  logic       clk,
  input  ctlStrobe_t ctl,
  input  state_t     loadVal,
  output state_t     stateQ
);
  state_t stateReg;
  state_t nextVal;

  skipSeqNext #(.USE_TOGGLE(USE_TOGGLE)) u_next (
    .cur(stateReg),
    .nxt(nextVal)
  );

  always_ff @(posedge clk) begin
    if (ctl.clear)      stateReg <= '0;
    else if (ctl.load)  stateReg <= loadVal;
    else if (ctl.step)  stateReg <= nextVal;
  end

  assign stateQ = stateReg;

  a_r1_clear: assert property (@(posedge clk) ctl.clear |=> stateReg == 3'b000);

  a_r2_loop_000: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.step && stateReg == 3'b000) |=> stateReg == 3'b010);
  a_r2_loop_010: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.step && stateReg == 3'b010) |=> stateReg == 3'b011);
  a_r2_loop_011: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.step && stateReg == 3'b011) |=> stateReg == 3'b101);
  a_r2_loop_101: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.step && stateReg == 3'b101) |=> stateReg == 3'b110);
  a_r2_loop_110: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.step && stateReg == 3'b110) |=> stateReg == 3'b000);

  a_r3_hold: assert property (@(posedge clk) disable iff (ctl.clear)
    (!ctl.load && !ctl.step) |=> $stable(stateReg));

  a_r4_load: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.load |=> stateReg == $past(loadVal));

  a_r5_from001: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.step && stateReg == 3'b001) |=> stateReg == 3'b100);
  a_r5_from100: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.step && stateReg == 3'b100) |=> stateReg == 3'b000);

  a_r6_from111: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.step && stateReg == 3'b111) |=> stateReg == 3'b110);
endmodule

// File: rtl/skipSeqCounter.sv
module skipSeqCounter
  import skipSeqPkg::*;
#(
  parameter bit USE_TOGGLE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       loadEn,
  input  logic [2:0] loadVal,
  output logic [2:0] stateOut
);
  ctlStrobe_t ctl;

  skipSeqCtrl u_ctrl (
    .rst(rst),
    .enable(enable),
    .loadEn(loadEn),
    .ctl(ctl)
  );

  skipSeqDatapath #(.USE_TOGGLE(USE_TOGGLE)) u_dp (
    .clk(clk),
    .ctl(ctl),
    .loadVal(loadVal),
    .stateQ(stateOut)
  );
endmodule

// File: tb/tb_skipSeqCounter.sv
module tb_skipSeqCounter;
  logic clk = 1'b0;
  logic rst, enable, loadEn;
  logic [2:0] loadVal;
  logic [2:0] stateD, stateT;
  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  skipSeqCounter #(.USE_TOGGLE(1'b0)) dut (
    .clk(clk), .rst(rst), .enable(enable), .loadEn(loadEn),
    .loadVal(loadVal), .stateOut(stateD));

  skipSeqCounter #(.USE_TOGGLE(1'b1)) dutToggle (
    .clk(clk), .rst(rst), .enable(enable), .loadEn(loadEn),
    .loadVal(loadVal), .stateOut(stateT));

  function automatic logic [2:0] expectNext(input logic [2:0] s);
    case (s)
      3'b000: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b101;
      3'b101: return 3'b110;
      3'b110: return 3'b000;
      3'b001: return 3'b100;
      3'b100: return 3'b000;
      default: return 3'b110;
    endcase
  endfunction

  function automatic bit inLoop(input logic [2:0] s);
    return s == 3'b000 || s == 3'b010 || s == 3'b011 || s == 3'b101 || s == 3'b110;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic r, input logic e, input logic l, input logic [2:0] v);
    @(negedge clk);
    rst = r; enable = e; loadEn = l; loadVal = v;
  endtask

  task automatic loadState(input logic [2:0] v);
    drive(1'b0, 1'b0, 1'b1, v);
    tick();
  endtask

  task automatic testReset();
    drive(1'b0, 1'b0, 1'b1, 3'b101);
    tick();
    drive(1'b1, 1'b1, 1'b1, 3'b111);
    tick();
    check("R1 clear over load/enable", stateD, 3'b000);
    check("R1 clear toggle build", stateT, 3'b000);
  endtask

  task automatic testLoop();
    logic [2:0] exp = 3'b000;
    drive(1'b1, 1'b0, 1'b0, 3'b000);
    tick();
    drive(1'b0, 1'b1, 1'b0, 3'b000);
    for (int i = 0; i < 10; i++) begin
      exp = expectNext(exp);
      tick();
      check("R2 loop step", stateD, exp);
    end
  endtask

  task automatic testHold();
    loadState(3'b011);
    drive(1'b0, 1'b0, 1'b0, 3'b110);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3 hold with enable low", stateD, 3'b011);
    end
  endtask

  task automatic testLoad();
    loadState(3'b010);
    drive(1'b0, 1'b1, 1'b1, 3'b111);
    tick();
    check("R4 load beats enable", stateD, 3'b111);
    drive(1'b0, 1'b0, 1'b1, 3'b001);
    tick();
    check("R4 load with enable low", stateD, 3'b001);
  endtask

  task automatic testAllSuccessors();
    for (int s = 0; s < 8; s++) begin
      loadState(3'(s));
      drive(1'b0, 1'b1, 1'b0, 3'b000);
      tick();
      if (s == 1 || s == 4)
        check("R5 unused successor", stateD, expectNext(3'(s)));
      else if (s == 7)
        check("R6 unused successor", stateD, expectNext(3'(s)));
      else
        check("R2 loop successor", stateD, expectNext(3'(s)));
      check("R8 toggle build matches", stateT, stateD);
    end
  endtask

  task automatic testRecovery();
    for (int s = 0; s < 8; s++) begin
      int steps = 0;
      loadState(3'(s));
      drive(1'b0, 1'b1, 1'b0, 3'b000);
      while (!inLoop(stateD) && steps < 4) begin
        tick();
        steps++;
      end
      checkCount++;
      if (steps > 2 || !inLoop(stateD)) begin
        failCount++;
        $display("FAIL R7 recovery from %b: actual %0d steps expected at most 2", 3'(s), steps);
      end
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; enable = 1'b0; loadEn = 1'b0; loadVal = 3'b000;
    tick();
    tick();
    check("R1 reset state", stateD, 3'b000);
    testReset();
    testLoop();
    testHold();
    testLoad();
    testAllSuccessors();
    testRecovery();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule